// File: doc/BRIEF.md
# Ternary Weight Dot-Product Engine

This block forms the dot product of a stream of signed 8-bit activations with a stream of ternary weights. Each weight is a 2-bit code that means +1, -1 or 0. No per-element multiplier is used. A +1 weight adds the activation into a wide signed accumulator and a -1 weight subtracts it. A 0 weight leaves the accumulator register disabled for that element and bumps a skip counter. When the element flagged as last is accepted, the finished sum is multiplied once by an unsigned Q8.8 layer scale. The product is shifted right arithmetically by the fraction width, saturated to a 32-bit signed result and registered for output together with the number of skipped elements in that vector.

A two-state controller sequences the block. In state ST_GATHER the input stream is open (`in_ready` high) and elements are accumulated. The transition ST_GATHER -> ST_PRESENT happens at the clock edge that accepts an element with `in_last` set. At that edge the result and the skip count are registered, and the accumulator and the skip counter are cleared. In state ST_PRESENT the result is offered with `out_valid` and `in_ready` is held low, so no new vector can overwrite it. The transition ST_PRESENT -> ST_GATHER happens at the first edge where `out_ready` is high. The reserved code 11 behaves as a zero weight and also sets a sticky error flag, which only reset clears.

Top module: `ternary_dot_engine`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, `code_err` is 0 and `out_result` is 0.
- R2: An accepted element with weight code 01 adds its sign-extended activation to the running sum.
- R3: An accepted element with weight code 10 subtracts its sign-extended activation from the running sum.
- R4: An accepted element with weight code 00 leaves the running sum unchanged and adds one to the skip count reported in `out_skips` for its vector.
- R5: Weight code 11 acts exactly like code 00 on the sum and the skip count, and it sets `code_err`; once set, `code_err` stays 1 until reset.
- R6: `out_result` equals the vector's sum multiplied by `scale_q88` (unsigned, 8 fraction bits), arithmetically shifted right by 8 (rounding toward minus infinity) and saturated to 32-bit signed. `scale_q88` is sampled at the edge that accepts the last element.
- R7: `out_valid` is high in the cycle right after the edge that accepts an element with `in_last` = 1, and `out_skips` then holds the skip count of that vector, counting the last element.
- R8: While `out_valid` is high, `in_ready` is low and `out_result` and `out_skips` hold steady until an edge with `out_ready` high. After that edge `out_valid` is 0 and `in_ready` is 1, and the next vector starts from a sum of zero.
- R9: A cycle with `in_valid` low, or with `in_ready` low, changes neither the sum, the skip count nor `code_err`, whatever `in_act`, `in_wcode` and `in_last` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Engine accepts an element this cycle |
| in_act | input | 8 | Signed activation |
| in_wcode | input | 2 | Weight code: 00 zero, 01 plus one, 10 minus one, 11 reserved |
| in_last | input | 1 | Element closes the current vector |
| scale_q88 | input | 16 | Unsigned layer scale, 8 fraction bits |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Scaled, saturated signed dot product |
| out_skips | output | 17 | Zero-weight elements skipped in the vector |
| code_err | output | 1 | Sticky flag: reserved weight code seen |

## Verification
The result, the skip count and the raised `out_valid` are all due in the cycle right after the edge that accepts the last element. The bench drives inputs on falling edges and samples once, at the falling edge after that accepting edge, comparing against a sum and scale product it works out itself. While the result is held back, every stall cycle is sampled at its falling edge for a low `in_ready` and unchanged outputs. Release is checked one edge after `out_ready` is raised. Idle bubbles carrying junk data are placed inside vectors, and junk is offered while the engine is stalled, so any data taken without a handshake shows up in the next expected result.

// File: rtl/tdot_pkg.sv
package tdot_pkg;

    typedef enum logic [1:0] {
        WC_ZERO  = 2'b00,
        WC_PLUS  = 2'b01,
        WC_MINUS = 2'b10,
        WC_RSVD  = 2'b11
    } wcode_e;

    typedef enum logic {
        ST_GATHER  = 1'b0,
        ST_PRESENT = 1'b1
    } state_e;

    typedef struct packed {
        logic en;    // accumulator works on this element
        logic neg;   // subtract instead of add
        logic skip;  // element counted as skipped
        logic bad;   // reserved code seen
    } op_t;

endpackage

// File: rtl/tdot_decode.sv
module tdot_decode
    import tdot_pkg::*;
(
    input  logic [1:0] code,
    output op_t        op
);

    always_comb begin
        op = '0;
        unique case (wcode_e'(code))
            WC_PLUS:  op.en = 1'b1;
            WC_MINUS: begin
                op.en  = 1'b1;
                op.neg = 1'b1;
            end
            WC_ZERO:  op.skip = 1'b1;
            WC_RSVD:  begin
                op.skip = 1'b1;
                op.bad  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/tdot_accum.sv
module tdot_accum
    import tdot_pkg::*;
#(
    parameter int ACT_W = 8,
    parameter int ACC_W = 24,
    parameter int CNT_W = 17
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic                    close,
    input  op_t                     op,
    input  logic signed [ACT_W-1:0] act,
    output logic signed [ACC_W-1:0] sum_next,
    output logic [CNT_W-1:0]        skip_next
);

    localparam int EXT_W = ACC_W - ACT_W;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] act_x;
    logic [CNT_W-1:0]        skip_q;

    assign act_x = {{EXT_W{act[ACT_W-1]}}, act};

    // Value the vector would hold after this element
    always_comb begin
        sum_next  = acc_q;
        skip_next = skip_q;
        if (step) begin
            if (op.en) begin
                sum_next = op.neg ? (acc_q - act_x) : (acc_q + act_x);
            end
            if (op.skip) begin
                skip_next = skip_q + 1'b1;
            end
        end
    end

    // Register enable is off for zero weights
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (close) begin
            acc_q <= '0;
        end else if (step && op.en) begin
            acc_q <= sum_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_q <= '0;
        end else if (close) begin
            skip_q <= '0;
        end else if (step && op.skip) begin
            skip_q <= skip_next;
        end
    end

    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && op.skip && !close) |=> $stable(acc_q)); // R4

    AST_PLUS_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && op.en && !op.neg && !close) |=> (acc_q == $past(acc_q) + $past(act_x))); // R2

    AST_MINUS_SUBS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && op.en && op.neg && !close) |=> (acc_q == $past(acc_q) - $past(act_x))); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !close) |=> ($stable(acc_q) && $stable(skip_q))); // R9

    AST_CLEAR_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> (acc_q == '0 && skip_q == '0)); // R8

endmodule

// File: rtl/tdot_scale.sv
module tdot_scale #(
    parameter int ACC_W   = 24,
    parameter int SCALE_W = 16,
    parameter int FRAC_W  = 8,
    parameter int OUT_W   = 32
) (
    input  logic signed [ACC_W-1:0] sum,
    input  logic [SCALE_W-1:0]      scale,
    output logic signed [OUT_W-1:0] result
);

    localparam int PW = ACC_W + SCALE_W + 1;

    logic signed [PW-1:0] sum_x;
    logic signed [PW-1:0] scl_x;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;

    assign sum_x   = {{(PW-ACC_W){sum[ACC_W-1]}}, sum};
    assign scl_x   = {{(PW-SCALE_W){1'b0}}, scale};
    assign prod    = sum_x * scl_x;
    assign shifted = prod >>> FRAC_W;

    generate
        if (PW > OUT_W) begin : g_sat
            logic [PW-OUT_W:0] hi;
            assign hi = shifted[PW-1:OUT_W-1];
            always_comb begin
                if (hi == '0 || hi == '1) begin
                    result = shifted[OUT_W-1:0];
                end else if (shifted[PW-1]) begin
                    result = {1'b1, {(OUT_W-1){1'b0}}};
                end else begin
                    result = {1'b0, {(OUT_W-1){1'b1}}};
                end
            end
        end else if (PW == OUT_W) begin : g_same
            assign result = shifted;
        end else begin : g_ext
            assign result = {{(OUT_W-PW){shifted[PW-1]}}, shifted};
        end
    endgenerate

    always_comb begin
        AST_SIGN_KEPT: assert (!(sum > 0 && result < 0) && !(sum < 0 && result > 0)); // R6
    end

endmodule

// File: rtl/ternary_dot_engine.sv
module ternary_dot_engine
    import tdot_pkg::*;
#(
    parameter int ACT_W   = 8,
    parameter int ACC_W   = 24,
    parameter int SCALE_W = 16,
    parameter int FRAC_W  = 8,
    parameter int OUT_W   = 32,
    parameter int CNT_W   = 17
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [ACT_W-1:0] in_act,
    input  logic [1:0]              in_wcode,
    input  logic                    in_last,
    input  logic [SCALE_W-1:0]      scale_q88,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic signed [OUT_W-1:0] out_result,
    output logic [CNT_W-1:0]        out_skips,
    output logic                    code_err
);

    state_e state_q;
    state_e state_d;

    op_t                     op;
    logic                    fire;
    logic                    close;
    logic signed [ACC_W-1:0] sum_next;
    logic [CNT_W-1:0]        skip_next;
    logic signed [OUT_W-1:0] scaled;

    assign fire  = in_valid && in_ready;
    assign close = fire && in_last;

    tdot_decode u_decode (
        .code (in_wcode),
        .op   (op)
    );

    tdot_accum #(
        .ACT_W (ACT_W),
        .ACC_W (ACC_W),
        .CNT_W (CNT_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (fire),
        .close     (close),
        .op        (op),
        .act       (in_act),
        .sum_next  (sum_next),
        .skip_next (skip_next)
    );

    tdot_scale #(
        .ACC_W   (ACC_W),
        .SCALE_W (SCALE_W),
        .FRAC_W  (FRAC_W),
        .OUT_W   (OUT_W)
    ) u_scale (
        .sum    (sum_next),
        .scale  (scale_q88),
        .result (scaled)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GATHER:  if (close)     state_d = ST_PRESENT;
            ST_PRESENT: if (out_ready) state_d = ST_GATHER;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_GATHER;
        end else begin
            state_q <= state_d;
        end
    end

    // Handshake outputs decoded from the state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_GATHER:  in_ready  = 1'b1;
            ST_PRESENT: out_valid = 1'b1;
        endcase
    end

    // Registered data outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
            out_skips  <= '0;
            code_err   <= 1'b0;
        end else begin
            if (close) begin
                out_result <= scaled;
                out_skips  <= skip_next;
            end
            if (fire && op.bad) begin
                code_err <= 1'b1;
            end
        end
    end

    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> out_valid); // R7

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_skips))); // R8

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid && in_ready)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |=> code_err); // R5

    AST_ERR_ONLY_ON_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_err) |-> $past(fire && in_wcode == 2'b11)); // R5

endmodule

// File: tb/ternary_dot_engine_bench.sv
`timescale 1ns/1ps
module ternary_dot_engine_bench;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic               in_ready;
    logic signed [7:0]  in_act;
    logic [1:0]         in_wcode;
    logic               in_last;
    logic [15:0]        scale_q88;
    logic               out_valid;
    logic               out_ready;
    logic signed [31:0] out_result;
    logic [16:0]        out_skips;
    logic               code_err;

    always #2.5 clk = ~clk;

    ternary_dot_engine u_ternary_dot_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_act     (in_act),
        .in_wcode   (in_wcode),
        .in_last    (in_last),
        .scale_q88  (scale_q88),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_result (out_result),
        .out_skips  (out_skips),
        .code_err   (code_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit err_exp = 1'b0;

    logic signed [7:0] va [64];
    logic [1:0]        vc [64];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint exp_res(input longint s, input longint sc);
        longint p;
        p = (s * sc) >>> 8;
        if (p > 64'sd2147483647) p = 64'sd2147483647;
        if (p < -64'sd2147483648) p = -64'sd2147483648;
        return p;
    endfunction

    task automatic run_vec(input int n, input longint sc, input int stall, input int bubbles);
        longint s  = 0;
        int     sk = 0;
        logic signed [31:0] held;
        scale_q88 = sc[15:0];
        for (int i = 0; i < n; i++) begin
            case (vc[i])
                2'b01: s = s + longint'(va[i]);
                2'b10: s = s - longint'(va[i]);
                2'b11: begin sk++; err_exp = 1'b1; end
                default: sk++;
            endcase
            for (int b = 0; b < bubbles; b++) begin
                in_valid = 1'b0;
                in_act   = 8'($urandom);
                in_wcode = 2'b01;
                in_last  = 1'b1;
                @(posedge clk); @(negedge clk);
            end
            in_valid = 1'b1;
            in_act   = va[i];
            in_wcode = vc[i];
            in_last  = (i == n - 1);
            @(posedge clk); @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        check(out_valid == 1'b1, "R7 out_valid after last", out_valid, 1);
        check(out_result == exp_res(s, sc), "R2/R3/R6/R9 scaled sum", longint'(out_result), exp_res(s, sc));
        check(out_skips == sk, "R4 skip count", out_skips, sk);
        check(code_err == err_exp, "R5 sticky error", code_err, err_exp);
        held = out_result;
        for (int c = 0; c < stall; c++) begin
            out_ready = 1'b0;
            in_valid  = 1'b1;
            in_act    = 8'($urandom);
            in_wcode  = 2'b01;
            in_last   = 1'b1;
            @(posedge clk); @(negedge clk);
            check(in_ready == 1'b0 && out_valid == 1'b1 && out_result == held,
                  "R8 hold while stalled", longint'(out_result), longint'(held));
        end
        in_valid  = 1'b0;
        in_last   = 1'b0;
        out_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        out_ready = 1'b0;
        check(out_valid == 1'b0 && in_ready == 1'b1, "R8 release", out_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R7 run did not finish actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_act    = '0;
        in_wcode  = '0;
        in_last   = 1'b0;
        scale_q88 = 16'h0100;
        out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(out_valid == 1'b0 && in_ready == 1'b1, "R1 handshake after reset", out_valid, 0);
        check(code_err == 1'b0 && out_result == 0, "R1 outputs after reset", longint'(out_result), 0);

        // R3 single element, most negative activation subtracted
        va[0] = -8'sd128; vc[0] = 2'b10;
        run_vec(1, 16'h0100, 0, 0);

        // R4 all-zero weights
        for (int i = 0; i < 4; i++) begin va[i] = 8'($urandom); vc[i] = 2'b00; end
        run_vec(4, 16'h0100, 2, 1);

        // R6 negative sum rounds toward minus infinity
        va[0] = 8'sd1; vc[0] = 2'b10;
        va[1] = 8'sd5; vc[1] = 2'b00;
        run_vec(2, 16'h0080, 1, 0);

        // R6 zero scale
        va[0] = 8'sd99; vc[0] = 2'b01;
        va[1] = 8'sd3;  vc[1] = 2'b01;
        run_vec(2, 16'h0000, 0, 0);

        // R6 largest scale with large sum
        for (int i = 0; i < 8; i++) begin va[i] = -8'sd128; vc[i] = 2'b10; end
        run_vec(8, 16'hFFFF, 0, 0);

        // Random vectors, valid codes only
        for (int v = 0; v < 20; v++) begin
            int n;
            n = 1 + int'($urandom % 40);
            for (int i = 0; i < n; i++) begin
                va[i] = 8'($urandom);
                vc[i] = 2'($urandom % 3);
            end
            run_vec(n, longint'($urandom % 65536), int'($urandom % 4), int'($urandom % 2));
        end

        // R5 reserved code behaves as zero and raises the flag
        va[0] = 8'sd50; vc[0] = 2'b11;
        va[1] = 8'sd7;  vc[1] = 2'b01;
        run_vec(2, 16'h0100, 0, 0);

        // R5 flag stays set over a clean vector
        va[0] = -8'sd20; vc[0] = 2'b01;
        va[1] = 8'sd30;  vc[1] = 2'b10;
        va[2] = 8'sd4;   vc[2] = 2'b00;
        run_vec(3, 16'h0300, 1, 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule